// File: doc/BRIEF.md
# Host Port Request Controller

This block holds the status flags, request enables and request-pin logic of a parallel host port that links an external host processor to a DSP core. Data from the host goes through two registers in turn: a host-side transmit register and, behind it, a DSP-side receive register. Data from the DSP goes through one host-side receive register. The host reads all flags and enables in one 8-bit control/status word, and it writes the enables through the same word.

An active-low request pin tells the host when to act. In interrupt mode the pin combines three status sources, and each source has its own enable. In DMA mode the receive-request enable stops acting as an enable and selects the transfer direction instead, and the pin then paces the DMA transfers. Three things empty the host-to-DSP path: a software reset, a host reset, and an initialise command issued together with the transmit-request enable.

Top module: `hostport_req_ctrl`

## Requirements
- R1: The control/status word uses these bits. Bit 0 is receive-full and bit 1 is transmit-empty. Bit 2 is path-ready, and it is read-only. Bit 3 is the receive-request enable and bit 4 is the transmit-request enable. Bit 5 is the ready-request enable and bit 6 is DMA mode. Bit 7 is the initialise command; it always reads 0. A host write to bits 0 to 2 does not change those bits.
- R2: A host write to the transmit register makes transmit-empty read 0 after the next clock edge. On the edge after that, the word moves unchanged into the DSP-side register, but only if that register is empty. After the move, transmit-empty reads 1 again.
- R3: Path-ready reads 1 only when both the host transmit register and the DSP-side receive register are empty.
- R4: A DSP write makes receive-full read 1 after the next edge, and the host sees the written data. A host read clears receive-full after the next edge.
- R5: With DMA mode off, the request pin is low exactly when any of these holds: (receive enable AND receive-full), (transmit enable AND transmit-empty), (ready enable AND path-ready). The pin follows the registered flags combinationally.
- R6: All three flags read their true values whatever the enables are.
- R7: With DMA mode on and the receive enable at 1 (direction DSP to DMA), the pin is low exactly when receive-full is 1. The other two enables have no effect.
- R8: With DMA mode on and the receive enable at 0 (direction DMA to DSP), the pin is low exactly when transmit-empty is 1. The ready source is ignored.
- R9: After hardware reset, all enables read 0, transmit-empty and path-ready read 1, receive-full reads 0, and the pin is high.
- R10: A software reset clears all enables, including the receive enable. It also empties both data paths, so path-ready reads 1 and receive-full reads 0.
- R11: A host reset empties the host-to-DSP path, so path-ready reads 1. The enables keep their values.
- R12: A control write with bit 7 = 1 and bit 4 = 1 empties the host-to-DSP path. The same write with bit 4 = 0 leaves the path unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_rst | input | 1 | Software reset from the DSP core |
| host_rst | input | 1 | Host reset of the transmit path |
| host_ctl_we | input | 1 | Host write strobe for the control word |
| host_ctl_wdata | input | 8 | Control word write data |
| host_ctl_rdata | output | 8 | Control/status word read data |
| host_tx_we | input | 1 | Host write strobe for the transmit register |
| host_tx_data | input | DATA_W | Host transmit data |
| host_rx_re | input | 1 | Host read strobe for the receive register |
| host_rx_data | output | DATA_W | Host receive register contents |
| dsp_rx_re | input | 1 | DSP read strobe for the DSP-side receive register |
| dsp_rx_data | output | DATA_W | DSP-side receive register contents |
| dsp_rx_full | output | 1 | DSP-side receive register holds data |
| dsp_tx_we | input | 1 | DSP write strobe for the host receive register |
| dsp_tx_data | input | DATA_W | DSP transmit data |
| host_req_n | output | 1 | Active-low host request |

## Verification
The bench builds the block with DATA_W = 16. This width is enough to show that both data paths move words unchanged, and the whole request equation still fits in a short run. A vector table sets the transmit path to one of three fill levels: empty, one word held in the DSP-side register, and both stages full. Together with the receive-full state, these levels reach every combination of flags that can occur, so each enable and each DMA direction is tested against both a set and a clear source.

// File: rtl/hpr_pkg.sv
// Package hpr_pkg
// Holds the bit layout of the host control/status word and the type that
// carries the request enables. Every module of the request controller uses it.
package hpr_pkg;
    localparam int CTL_W      = 8;
    localparam int B_RXFULL   = 0;
    localparam int B_TXEMPTY  = 1;
    localparam int B_PATHRDY  = 2;
    localparam int B_RXEN     = 3;
    localparam int B_TXEN     = 4;
    localparam int B_RDYEN    = 5;
    localparam int B_DMA      = 6;
    localparam int B_INIT     = 7;

    typedef struct packed {
        logic dma_mode;
        logic rdy_en;
        logic tx_en;
        logic rx_en;
    } hpr_en_t;
endpackage

// File: rtl/hpr_ctl_reg.sv
// Module hpr_ctl_reg
// Holds the four request enables, which the host writes.
// It also decodes the initialise command into a one-cycle flush request.
// Assumes the write data is valid in the same cycle as the strobe.
module hpr_ctl_reg
    import hpr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sw_rst,
    input  logic    we,
    input  logic    init_bit,
    input  hpr_en_t wr_en,
    output hpr_en_t en,
    output logic    init_flush
);
    // Enable register; a hardware or software reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            en <= '0;
        end else if (we) begin
            en <= wr_en;
        end
    end

    // The initialise command flushes only when it is written together with the transmit enable.
    always_comb begin
        init_flush = we && init_bit && wr_en.tx_en;
    end
endmodule

// File: rtl/hpr_tx_path.sv
// Module hpr_tx_path
// Two-stage path from the host to the DSP: a host transmit register feeding
// a DSP-side receive register. A flush empties both stages, and it wins over
// a write made in the same cycle.
// Assumes the host writes only while the transmit stage is empty; a
// write to a full stage replaces the word waiting there.
module hpr_tx_path #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_data,
    input  logic              dsp_re,
    output logic [DATA_W-1:0] dsp_data,
    output logic              tx_empty,
    output logic              hrx_full
);
    logic              tx_full;
    logic [DATA_W-1:0] tx_q;
    logic              move;

    // A move happens when the transmit stage holds data and the DSP-side register is empty.
    always_comb begin
        move = tx_full && !hrx_full;
    end

    // Transmit stage; a new host write takes priority over the move.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            tx_full <= 1'b0;
        end else if (host_we) begin
            tx_full <= 1'b1;
        end else if (move) begin
            tx_full <= 1'b0;
        end
    end

    // Transmit data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (host_we && !flush) begin
            tx_q <= host_data;
        end
    end

    // DSP-side receive stage; it fills on a move and empties on a DSP read.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hrx_full <= 1'b0;
        end else if (move) begin
            hrx_full <= 1'b1;
        end else if (dsp_re) begin
            hrx_full <= 1'b0;
        end
    end

    // DSP-side data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsp_data <= '0;
        end else if (move && !flush) begin
            dsp_data <= tx_q;
        end
    end

    // Empty flag seen by the host.
    always_comb begin
        tx_empty = !tx_full;
    end
endmodule

// File: rtl/hpr_rx_path.sv
// Module hpr_rx_path
// Host-side receive register, which the DSP fills and the host empties.
// A DSP write wins over a host read made in the same cycle, and a flush wins over both.
module hpr_rx_path #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              dsp_we,
    input  logic [DATA_W-1:0] dsp_data,
    input  logic              host_re,
    output logic [DATA_W-1:0] host_data,
    output logic              rx_full
);
    // Full flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rx_full <= 1'b0;
        end else if (dsp_we) begin
            rx_full <= 1'b1;
        end else if (host_re) begin
            rx_full <= 1'b0;
        end
    end

    // Data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_data <= '0;
        end else if (dsp_we && !flush) begin
            host_data <= dsp_data;
        end
    end
endmodule

// File: rtl/hpr_req_logic.sv
// Module hpr_req_logic
// Combinational request-pin equation. In interrupt mode it ORs the three
// enabled sources. In DMA mode the receive enable selects the direction,
// and only the flag for that direction drives the pin.
// ACTIVE_LOW selects the polarity of the pin.
module hpr_req_logic
    import hpr_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  hpr_en_t en,
    input  logic    rx_full,
    input  logic    tx_empty,
    input  logic    path_rdy,
    output logic    req_pin
);
    logic req;

    // Picks the request source from the mode and the enables.
    always_comb begin
        if (en.dma_mode) begin
            req = en.rx_en ? rx_full : tx_empty;
        end else begin
            req = (en.rx_en && rx_full) || (en.tx_en && tx_empty) || (en.rdy_en && path_rdy);
        end
    end

    generate
        if (ACTIVE_LOW) begin : g_low
            assign req_pin = !req;
        end else begin : g_high
            assign req_pin = req;
        end
    endgenerate
endmodule

// File: rtl/hostport_req_ctrl.sv
// Module hostport_req_ctrl
// Top level of the host port request controller. It joins the enable
// register, both data paths and the request equation, and it builds the
// control/status word the host reads.
// Assumes all strobes are synchronous to clk and last one cycle per access.
module hostport_req_ctrl
    import hpr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              host_rst,
    input  logic              host_ctl_we,
    input  logic [7:0]        host_ctl_wdata,
    output logic [7:0]        host_ctl_rdata,
    input  logic              host_tx_we,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_rx_re,
    output logic [DATA_W-1:0] host_rx_data,
    input  logic              dsp_rx_re,
    output logic [DATA_W-1:0] dsp_rx_data,
    output logic              dsp_rx_full,
    input  logic              dsp_tx_we,
    input  logic [DATA_W-1:0] dsp_tx_data,
    output logic              host_req_n
);
    hpr_en_t en;
    hpr_en_t wr_en;
    logic    init_flush;
    logic    tx_flush;
    logic    tx_empty;
    logic    rx_full;
    logic    path_rdy;
    logic    unused_ro_bits;

    // Unpacks the writable enable bits from the host write data.
    always_comb begin
        wr_en.dma_mode = host_ctl_wdata[B_DMA];
        wr_en.rdy_en   = host_ctl_wdata[B_RDYEN];
        wr_en.tx_en    = host_ctl_wdata[B_TXEN];
        wr_en.rx_en    = host_ctl_wdata[B_RXEN];
        unused_ro_bits = ^host_ctl_wdata[B_PATHRDY:B_RXFULL];
    end

    hpr_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .we        (host_ctl_we),
        .init_bit  (host_ctl_wdata[B_INIT]),
        .wr_en     (wr_en),
        .en        (en),
        .init_flush(init_flush)
    );

    // Every source that empties the host-to-DSP path.
    always_comb begin
        tx_flush = sw_rst || host_rst || init_flush;
    end

    hpr_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (tx_flush),
        .host_we  (host_tx_we),
        .host_data(host_tx_data),
        .dsp_re   (dsp_rx_re),
        .dsp_data (dsp_rx_data),
        .tx_empty (tx_empty),
        .hrx_full (dsp_rx_full)
    );

    hpr_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (sw_rst),
        .dsp_we   (dsp_tx_we),
        .dsp_data (dsp_tx_data),
        .host_re  (host_rx_re),
        .host_data(host_rx_data),
        .rx_full  (rx_full)
    );

    // Path-ready: both stages of the host-to-DSP path are empty.
    always_comb begin
        path_rdy = tx_empty && !dsp_rx_full;
    end

    hpr_req_logic #(.ACTIVE_LOW(1'b1)) u_req (
        .en      (en),
        .rx_full (rx_full),
        .tx_empty(tx_empty),
        .path_rdy(path_rdy),
        .req_pin (host_req_n)
    );

    // Builds the control/status word; the initialise bit always reads 0.
    always_comb begin
        host_ctl_rdata            = '0;
        host_ctl_rdata[B_RXFULL]  = rx_full;
        host_ctl_rdata[B_TXEMPTY] = tx_empty;
        host_ctl_rdata[B_PATHRDY] = path_rdy;
        host_ctl_rdata[B_RXEN]    = en.rx_en;
        host_ctl_rdata[B_TXEN]    = en.tx_en;
        host_ctl_rdata[B_RDYEN]   = en.rdy_en;
        host_ctl_rdata[B_DMA]     = en.dma_mode;
    end
endmodule

// File: rtl/hpr_checker.sv
// Module hpr_checker
// Property checks on the ports of hostport_req_ctrl. It is attached to the
// top module by the bind below.
module hpr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_rst,
    input logic       host_rst,
    input logic       host_ctl_we,
    input logic [7:0] host_ctl_wdata,
    input logic [7:0] host_ctl_rdata,
    input logic       host_tx_we,
    input logic       dsp_tx_we,
    input logic       dsp_rx_full,
    input logic       host_req_n
);
    logic tx_flush_req;

    // Any request that empties the host-to-DSP path in this cycle.
    always_comb begin
        tx_flush_req = sw_rst || host_rst || (host_ctl_we && host_ctl_wdata[7] && host_ctl_wdata[4]);
    end

    p_init_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ctl_rdata[7]);

    p_txempty_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_tx_we && !tx_flush_req |=> !host_ctl_rdata[1]);

    p_ready_means_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_ctl_rdata[2] |-> host_ctl_rdata[1] && !dsp_rx_full);

    p_rxfull_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_tx_we && !sw_rst |=> host_ctl_rdata[0]);

    p_all_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ctl_rdata[6] && !host_ctl_rdata[5] && !host_ctl_rdata[4] && !host_ctl_rdata[3]
        |-> host_req_n);

    p_dma_out_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ctl_rdata[6] && host_ctl_rdata[3] |-> host_req_n == !host_ctl_rdata[0]);

    p_dma_in_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ctl_rdata[6] && !host_ctl_rdata[3] |-> host_req_n == !host_ctl_rdata[1]);

    p_sw_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> !host_ctl_rdata[3] && host_ctl_rdata[2] && !host_ctl_rdata[0]);

    p_host_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst && !host_ctl_we |=> host_ctl_rdata[2] && $stable(host_ctl_rdata[6:3]));
endmodule

bind hostport_req_ctrl hpr_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_rst        (sw_rst),
    .host_rst      (host_rst),
    .host_ctl_we   (host_ctl_we),
    .host_ctl_wdata(host_ctl_wdata),
    .host_ctl_rdata(host_ctl_rdata),
    .host_tx_we    (host_tx_we),
    .dsp_tx_we     (dsp_tx_we),
    .dsp_rx_full   (dsp_rx_full),
    .host_req_n    (host_req_n)
);

// File: tb/sim_hostport_req_ctrl.sv
// Bench for hostport_req_ctrl: a vector table for the request equation,
// then directed tests for reset, the data paths and the flush commands.
module sim_hostport_req_ctrl;
    localparam int DW = 16;
    localparam int NVEC = 13;
    // Fields: [7] dma, [6] ready en, [5] tx en, [4] rx en, [3] fill rx,
    // [2:1] tx fill level (0 empty, 1 DSP stage full, 2 both full), [0] request expected
    localparam logic [7:0] VEC [NVEC] = '{
        8'b0000_0000, 8'b0010_0001, 8'b0010_0100, 8'b0100_0001,
        8'b0100_0010, 8'b0001_1101, 8'b0001_0000, 8'b0000_1000,
        8'b1001_1001, 8'b1001_0000, 8'b1000_0001, 8'b1111_0000,
        8'b1000_0100
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_rst = 1'b0, host_rst = 1'b0;
    logic          host_ctl_we = 1'b0;
    logic [7:0]    host_ctl_wdata = '0;
    logic [7:0]    host_ctl_rdata;
    logic          host_tx_we = 1'b0;
    logic [DW-1:0] host_tx_data = '0;
    logic          host_rx_re = 1'b0;
    logic [DW-1:0] host_rx_data;
    logic          dsp_rx_re = 1'b0;
    logic [DW-1:0] dsp_rx_data;
    logic          dsp_rx_full;
    logic          dsp_tx_we = 1'b0;
    logic [DW-1:0] dsp_tx_data = '0;
    logic          host_req_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hostport_req_ctrl #(.DATA_W(DW)) u0 (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Waits for the next rising edge and then 1 ns more.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ctl_write(input logic [7:0] w);
        host_ctl_we = 1'b1; host_ctl_wdata = w; tick();
        host_ctl_we = 1'b0; host_ctl_wdata = '0;
    endtask

    task automatic host_write(input logic [DW-1:0] d);
        host_tx_we = 1'b1; host_tx_data = d; tick();
        host_tx_we = 1'b0;
    endtask

    task automatic dsp_write(input logic [DW-1:0] d);
        dsp_tx_we = 1'b1; dsp_tx_data = d; tick();
        dsp_tx_we = 1'b0;
    endtask

    task automatic pulse_sw_rst();
        sw_rst = 1'b1; tick(); sw_rst = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        #1;
        // R9: state after hardware reset
        check("R9 status", {24'd0, host_ctl_rdata}, 32'h06);
        check("R9 pin", {31'd0, host_req_n}, 32'd1);

        // Vector table for R5, R6, R7, R8
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] v;
            logic [2:0] flags;
            v = VEC[i];
            pulse_sw_rst();
            ctl_write({1'b0, v[7:4], 3'b000});
            if (v[3]) dsp_write(16'h1000 + 16'(i));
            if (v[2:1] != 2'd0) begin
                host_write(16'h2000 + 16'(i));
                tick();
            end
            if (v[2:1] == 2'd2) host_write(16'h3000 + 16'(i));
            flags = {v[2:1] == 2'd0, v[2:1] != 2'd2, v[3]};
            check($sformatf("R6 flags vec %0d", i), {29'd0, host_ctl_rdata[2:0]}, {29'd0, flags});
            check($sformatf("R5/R7/R8 pin vec %0d", i), {31'd0, host_req_n}, {31'd0, !v[0]});
        end

        // R1: bits 0 to 2 cannot be written, bit 7 reads 0
        pulse_sw_rst();
        ctl_write(8'b1000_0111);
        check("R1 read-only bits", {24'd0, host_ctl_rdata}, 32'h06);

        // R2 and R3: two-stage path timing and data
        pulse_sw_rst();
        host_write(16'hBEEF);
        check("R2 empty cleared", {31'd0, host_ctl_rdata[1]}, 32'd0);
        check("R3 not ready", {31'd0, host_ctl_rdata[2]}, 32'd0);
        tick();
        check("R2 empty after move", {31'd0, host_ctl_rdata[1]}, 32'd1);
        check("R3 not ready while DSP stage full", {31'd0, host_ctl_rdata[2]}, 32'd0);
        check("R2 data moved", {16'd0, dsp_rx_data}, 32'hBEEF);
        host_write(16'h1234);
        tick();
        check("R2 no move into full stage", {31'd0, host_ctl_rdata[1]}, 32'd0);
        dsp_rx_re = 1'b1; tick(); dsp_rx_re = 1'b0;
        tick();
        check("R2 second word moved", {16'd0, dsp_rx_data}, 32'h1234);
        dsp_rx_re = 1'b1; tick(); dsp_rx_re = 1'b0;
        check("R3 ready when both empty", {31'd0, host_ctl_rdata[2]}, 32'd1);

        // R4: host receive register
        dsp_write(16'hCAFE);
        check("R4 full set", {31'd0, host_ctl_rdata[0]}, 32'd1);
        check("R4 data", {16'd0, host_rx_data}, 32'hCAFE);
        host_rx_re = 1'b1; tick(); host_rx_re = 1'b0;
        check("R4 full cleared", {31'd0, host_ctl_rdata[0]}, 32'd0);

        // R10: software reset clears the enables and both paths
        ctl_write(8'b0111_1000);
        dsp_write(16'h0001);
        host_write(16'h0002);
        pulse_sw_rst();
        check("R10 status", {24'd0, host_ctl_rdata}, 32'h06);

        // R11: host reset flushes the transmit path and keeps the enables
        ctl_write(8'b0011_1000);
        host_write(16'h0003); tick();
        host_write(16'h0004);
        host_rst = 1'b1; tick(); host_rst = 1'b0;
        check("R11 path ready", {31'd0, host_ctl_rdata[2]}, 32'd1);
        check("R11 enables kept", {28'd0, host_ctl_rdata[6:3]}, 32'h7);

        // R12: the initialise command flushes only together with the transmit enable
        pulse_sw_rst();
        host_write(16'h0005); tick();
        ctl_write(8'b1000_0000);
        check("R12 no flush without tx enable", {31'd0, dsp_rx_full}, 32'd1);
        ctl_write(8'b1001_0000);
        check("R12 flush with tx enable", {31'd0, host_ctl_rdata[2]}, 32'd1);
        check("R12 tx enable set", {31'd0, host_ctl_rdata[4]}, 32'd1);

        // R9: hardware reset in the middle of operation
        ctl_write(8'b0011_1000);
        dsp_write(16'h0006);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        check("R9 status after reset", {24'd0, host_ctl_rdata}, 32'h06);
        check("R9 pin after reset", {31'd0, host_req_n}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule